// File: doc/BRIEF.md
# Triggered Multi-Frame Capture Controller

This controller sits between a free-running sample stream and a DMA engine. The stream carries four complex samples on each clock. A frame is 512 samples, so it spans 128 stream beats, and an end-of-frame marker flags the beat that holds a frame's final sample. The stream never pauses for the controller. A single-cycle trigger arms one capture window. During that window the controller copies stream beats onto an AXI4-Stream master until it has sent exactly the programmed number of frames' worth of beats. It then pulses `done` and returns to idle.

Capture starts at the first valid beat after the trigger, wherever that beat falls in the stream. TLAST comes from the stream's own frame marker, so the first frame delivered may be partial. A window of N frames can therefore touch N+1 frame regions. The final beat of the window always carries TLAST. The output register holds its beat while TREADY is low. Any sample that arrives during such a stall is discarded and recorded in a sticky overflow flag.

Top module: `capture_window_ctrl`

## Requirements
- R1: A trigger seen while idle raises `busy` in the following cycle and clears `overflow` at that edge. Each accepted trigger captures exactly one window.
- R2: `frames_m1` holds the frame count minus one, so value v selects v+1 frames and (v+1)×128 beats. The value is sampled when the trigger is accepted.
- R3: The number of TVALID&&TREADY handshakes in a window equals the programmed total, with no extra beat. In the cycle after the final handshake, `done` is high for exactly one cycle and `busy` is low. The controller is idle in the cycle after that.
- R4: Each beat is passed through unchanged. Lane k sits at bits [32k+31:32k], and bit 31 down to 16 of each lane is the imaginary part. TLAST is high on every beat whose input carried `in_eof`.
- R5: The final beat of a window always has TLAST high, whether or not it falls on a frame edge.
- R6: While `busy` is low, TVALID, TLAST and TDATA are all zero.
- R7: While TVALID is high and TREADY is low, the beat holds steady and the beat count does not advance.
- R8: If a valid sample arrives during a stall before the window is fully loaded, the sample is dropped and `overflow` sets. `overflow` stays set until the next accepted trigger.
- R9: A trigger seen while `busy` or `done` is high is ignored.
- R10: Cycles with `in_valid` low produce no beat, and their data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Single-cycle capture request |
| frames_m1 | input | 10 | Frames per window minus one |
| in_valid | input | 1 | Stream beat present |
| in_data | input | 128 | Four packed complex samples |
| in_eof | input | 1 | Beat holds the last sample of a frame |
| m_tready | input | 1 | Downstream accepts a beat |
| m_tdata | output | 128 | Output beat, zero when idle |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Frame edge or end of window |
| busy | output | 1 | Window capture in progress |
| done | output | 1 | One-cycle window-complete pulse |
| overflow | output | 1 | Sticky dropped-sample flag |

## Verification
Two events can land on the same beat: the window's final beat and a stream frame edge. An aligned window with a continuous stream and TREADY held high makes the final beat carry `in_eof`. In that case TLAST must appear exactly once, and the handshake count must still stop at the total. A second pair can also coincide: a stall held over the final loaded beat while new samples keep arriving. Random TREADY is used to provoke it. The test passes if the held beat stays stable, the late samples raise no overflow, and `done` appears only after the final handshake.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DONE    = 2'd2
    } cap_state_e;
endpackage

// File: rtl/cap_window_target.sv
module cap_window_target #(
    parameter int FW  = 10,
    parameter int CW  = 18,
    parameter int BPF = 128
) (
    input  logic [FW-1:0] frames_m1,
    output logic [CW-1:0] total_beats
);
    logic [CW-1:0] frames;

    always_comb begin
        frames      = CW'(frames_m1) + CW'(1);
        total_beats = frames * CW'(BPF);
    end
endmodule

// File: rtl/cap_beat_counter.sv
module cap_beat_counter #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] total_in,
    input  logic          inc,
    output logic          is_last,
    output logic          all_loaded
);
    typedef struct packed {
        logic [CW-1:0] total;
        logic [CW-1:0] loaded;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.total  = total_in;
            cnt_d.loaded = '0;
        end else if (inc) begin
            cnt_d.loaded = cnt_q.loaded + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_last    = (cnt_q.loaded == cnt_q.total - CW'(1));
    assign all_loaded = (cnt_q.loaded == cnt_q.total);
endmodule

// File: rtl/cap_out_stage.sv
module cap_out_stage #(
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          last_in,
    input  logic          final_in,
    input  logic          ready,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          last,
    output logic          final_beat,
    output logic          stall
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
        logic          last;
        logic          fin;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d.data  = din;
            beat_d.valid = 1'b1;
            beat_d.last  = last_in;
            beat_d.fin   = final_in;
        end else if (beat_q.valid && ready) begin
            beat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign data       = beat_q.data;
    assign valid      = beat_q.valid;
    assign last       = beat_q.last;
    assign final_beat = beat_q.fin;
    assign stall      = beat_q.valid && !ready;
endmodule

// File: rtl/capture_window_ctrl.sv
module capture_window_ctrl
    import cap_pkg::*;
#(
    parameter  int LANES         = 4,
    parameter  int SAMPLE_W      = 32,
    parameter  int FRAME_SAMPLES = 512,
    parameter  int MAX_FRAMES    = 1024,
    localparam int DW            = LANES * SAMPLE_W,
    localparam int BPF           = FRAME_SAMPLES / LANES,
    localparam int FW            = $clog2(MAX_FRAMES),
    localparam int CW            = $clog2(MAX_FRAMES * BPF + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trigger,
    input  logic [FW-1:0] frames_m1,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_eof,
    input  logic          m_tready,
    output logic [DW-1:0] m_tdata,
    output logic          m_tvalid,
    output logic          m_tlast,
    output logic          busy,
    output logic          done,
    output logic          overflow
);
    typedef struct packed {
        cap_state_e state;
        logic       overflow;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [CW-1:0] total_beats;
    logic          is_last, all_loaded;
    logic          stall, out_final;
    logic          start, take, final_hs;

    cap_window_target #(.FW(FW), .CW(CW), .BPF(BPF)) u_target (
        .frames_m1  (frames_m1),
        .total_beats(total_beats)
    );

    assign start    = (ctrl_q.state == ST_IDLE) && trigger;
    assign take     = (ctrl_q.state == ST_CAPTURE) && in_valid && !stall && !all_loaded;
    assign final_hs = m_tvalid && m_tready && out_final;

    cap_beat_counter #(.CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .total_in  (total_beats),
        .inc       (take),
        .is_last   (is_last),
        .all_loaded(all_loaded)
    );

    cap_out_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .din       (in_data),
        .last_in   (in_eof || is_last),
        .final_in  (is_last),
        .ready     (m_tready),
        .data      (m_tdata),
        .valid     (m_tvalid),
        .last      (m_tlast),
        .final_beat(out_final),
        .stall     (stall)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (trigger) begin
                    ctrl_d.state    = ST_CAPTURE;
                    ctrl_d.overflow = 1'b0;
                end
            end
            ST_CAPTURE: begin
                if (in_valid && stall && !all_loaded) ctrl_d.overflow = 1'b1;
                if (final_hs) ctrl_d.state = ST_DONE;
            end
            ST_DONE:  ctrl_d.state = ST_IDLE;
            default:  ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '{state: ST_IDLE, overflow: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign busy     = (ctrl_q.state == ST_CAPTURE);
    assign done     = (ctrl_q.state == ST_DONE);
    assign overflow = ctrl_q.overflow;
endmodule

// File: rtl/cap_window_checker.sv
module cap_window_checker #(
    parameter int DW  = 128,
    parameter int FW  = 10,
    parameter int CW  = 18,
    parameter int BPF = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trigger,
    input logic [FW-1:0] frames_m1,
    input logic          m_tready,
    input logic [DW-1:0] m_tdata,
    input logic          m_tvalid,
    input logic          m_tlast,
    input logic          busy,
    input logic          done,
    input logic          overflow
);
    logic [CW-1:0] win_total_q, hs_cnt_q;
    logic          accept_trig, hs;

    assign accept_trig = trigger && !busy && !done;
    assign hs          = m_tvalid && m_tready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_total_q <= '0;
            hs_cnt_q    <= '0;
        end else if (accept_trig) begin
            win_total_q <= (CW'(frames_m1) + CW'(1)) * CW'(BPF);
            hs_cnt_q    <= '0;
        end else if (hs) begin
            hs_cnt_q <= hs_cnt_q + CW'(1);
        end
    end

    AST_START_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept_trig |=> busy && !overflow); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> hs_cnt_q < win_total_q); // R3
    AST_DONE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hs_cnt_q == win_total_q); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R3
    AST_FINAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && busy && hs_cnt_q == win_total_q - CW'(1)) |-> m_tlast); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_tvalid && !m_tlast && m_tdata == '0); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !accept_trig) |=> overflow); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(hs && hs_cnt_q == win_total_q - CW'(1))) |=> busy); // R9
endmodule

bind capture_window_ctrl cap_window_checker #(
    .DW(DW), .FW(FW), .CW(CW), .BPF(BPF)
) u_checker (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .frames_m1(frames_m1),
    .m_tready(m_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tlast(m_tlast), .busy(busy), .done(done), .overflow(overflow)
);

// File: tb/tb_capture_window_ctrl.sv
module tb_capture_window_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 128;
    localparam int BPF = 128;
    localparam int FW  = 10;

    logic          clk = 1'b0;
    logic          rst_n, trigger, in_valid, in_eof, m_tready;
    logic [FW-1:0] frames_m1;
    logic [DW-1:0] in_data, m_tdata;
    logic          m_tvalid, m_tlast, busy, done, overflow;

    capture_window_ctrl dut (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .frames_m1(frames_m1),
        .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
        .m_tready(m_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tlast(m_tlast), .busy(busy), .done(done), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    int sp = 0;
    int total = 0, pushed = 0, hs = 0;
    bit ovf_exp = 0;
    bit prev_stall = 0;
    logic [DW-1:0] prev_data = '0;
    logic [DW:0] exp_q[$];

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] beat_data(int p);
        logic [DW-1:0] d;
        for (int l = 0; l < 4; l++)
            d[l*32 +: 32] = {16'(p / BPF), 16'((p % BPF) * 4 + l)};
        return d;
    endfunction

    task automatic drive_cycle(bit v, bit rdy, bit trg);
        logic [DW:0] e;
        bit eof_now;
        @(negedge clk);
        eof_now  = v && (sp % BPF == BPF - 1);
        in_valid = v;
        m_tready = rdy;
        trigger  = trg;
        in_eof   = eof_now;
        in_data  = v ? beat_data(sp) : {$urandom, $urandom, $urandom, $urandom};
        #1;
        if (prev_stall)
            check(m_tvalid && m_tdata == prev_data, "R7", "held beat", m_tdata, prev_data);
        if (!busy)
            check(!m_tvalid && !m_tlast && m_tdata == '0, "R6", "idle output", m_tdata, '0);
        if (m_tvalid && m_tready) begin
            if (exp_q.size() == 0) begin
                check(0, "R3", "unexpected extra beat", m_tdata, '0);
            end else begin
                e = exp_q.pop_front();
                check(m_tdata == e[DW-1:0], "R4 R10", "beat data", m_tdata, e[DW-1:0]);
                check(m_tlast == e[DW], (exp_q.size() == 0) ? "R5" : "R4", "tlast",
                      DW'(m_tlast), DW'(e[DW]));
            end
            hs++;
        end
        if (busy && v && pushed < total) begin
            if (m_tvalid && !m_tready) ovf_exp = 1;
            else begin
                exp_q.push_back({eof_now || (pushed == total - 1), beat_data(sp)});
                pushed++;
            end
        end
        prev_stall = m_tvalid && !m_tready;
        prev_data  = m_tdata;
        if (v) sp++;
    endtask

    task automatic run_window(int fsel, int vpct, int rpct, bit align, bit poke, bit dpoke);
        bit got_done = 0;
        bit trg_next = 0;
        frames_m1 = FW'(fsel);
        if (align) while (sp % BPF != 0) drive_cycle(1, 1, 0);
        drive_cycle(0, 1, 0);
        check(!busy, "R1", "idle before trigger", DW'(busy), '0);
        total = (fsel + 1) * BPF; pushed = 0; hs = 0; ovf_exp = 0;
        exp_q.delete();
        drive_cycle(0, 1, 1);
        for (int n = 0; n < 40000; n++) begin
            bit v, r, t;
            v = ($urandom % 100) < vpct;
            r = ($urandom % 100) < rpct;
            t = trg_next || (poke && ($urandom % 40 == 0));
            trg_next = 0;
            drive_cycle(v, r, t);
            if (n == 0) begin
                check(busy == 1'b1, "R1", "busy after trigger", DW'(busy), 1);
                check(overflow == 1'b0, "R8", "overflow cleared by trigger", DW'(overflow), 0);
            end
            if (done) begin
                got_done = 1;
                check(!busy, "R3", "busy low with done", DW'(busy), 0);
                break;
            end
            if (dpoke && hs == total) trg_next = 1;
        end
        check(got_done, "R3", "done pulse seen", DW'(got_done), 1);
        check(hs == total, "R2", "handshakes per window", DW'(hs), DW'(total));
        check(exp_q.size() == 0, "R3", "beats left undelivered", DW'(exp_q.size()), 0);
        check(overflow == ovf_exp, "R8", "overflow flag", DW'(overflow), DW'(ovf_exp));
        drive_cycle(1, 1, 0);
        check(!done && !busy, "R9", "idle after done (trigger in done ignored)",
              DW'({done, busy}), 0);
        check(overflow == ovf_exp, "R8", "overflow sticky after window", DW'(overflow), DW'(ovf_exp));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        rst_n = 0; trigger = 0; in_valid = 0; in_eof = 0; m_tready = 0;
        in_data = '0; frames_m1 = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !overflow, "R6", "reset status", DW'({busy, done, overflow}), 0);
        check(!m_tvalid && m_tdata == '0, "R6", "reset stream", m_tdata, '0);
        rst_n = 1;
        repeat (37) drive_cycle(1, 1, 0);
        run_window(0, 100, 100, 1, 0, 0);  // final beat on frame edge
        run_window(0, 70, 100, 0, 0, 0);   // mid-frame start with gaps
        run_window(2, 90, 60, 0, 1, 0);    // stalls, triggers while busy
        run_window(1, 100, 50, 0, 0, 1);   // trigger in done cycle
        run_window(4, 80, 85, 1, 1, 1);
        run_window(0, 100, 40, 0, 0, 0);   // heavy stalls on a short window
        run_window(3, 60, 95, 0, 0, 0);
        summary();
        $finish;
    end
endmodule